// File: doc/BRIEF.md
# Periodic descriptor slot scheduler

This block decides, once per frame, which interrupt-transfer descriptor slots get serviced and in what order. Software keeps two per-slot bitmaps: one that excludes slots from service, and one that marks where the periodic list ends. When a frame begins, the scheduler steps through the slots from index 0 upward. It passes over excluded slots and hands each remaining slot, one at a time, to a downstream transaction engine through an issue/done handshake.

When the slot that closes the list has been dealt with, or the top slot has been passed, the scheduler raises a one-cycle pulse. That pulse passes control to the asynchronous-list phase. The index of the slot under work is readable at all times, so software can avoid rewriting a descriptor that is in use. All register access goes through a command-coded port. A read code has bit 7 clear, and the matching write code is the same value with bit 7 set.

Top module: `periodic_slot_sched`

## Requirements
- R1: The exclusion map is read with code 18h and written with code 98h. The end-of-list map is read with 19h and written with 99h. A write takes effect at the clock edge where `cmd_valid` is high. A read returns the map on `cmd_rdata` combinationally in the same cycle. Bit n of each map belongs to slot n.
- R2: Code 1Ah returns the active slot index in bits 4:0, with every higher bit zero. Writing 9Ah or any other unknown write code changes no state. Reading an unknown code, or any cycle without `cmd_valid`, returns zero.
- R3: After reset both maps are zero, the active index is 0, and `issue` and `async_go` are low.
- R4: A `frame_start` sampled at edge k restarts the walk at slot 0, and slots are taken in ascending order. Each excluded slot costs one cycle. The first event of the walk (an issue, or the hand-off pulse) for slot j is visible after edge k+j+1.
- R5: For each slot whose exclusion bit is 0, `issue` goes high with `issue_slot` equal to that slot. Both are held until `done` is sampled high. While they are held, the 1Ah readout equals `issue_slot`.
- R6: When a processed slot whose end-of-list bit is 1 completes, the walk stops. `async_go` is high for exactly one cycle, in the cycle after `done` is sampled, and `issue` stays low.
- R7: If no end-of-list bit is found, the walk stops after slot 31 and still pulses `async_go`.
- R8: A slot with both its exclusion bit and its end-of-list bit set ends the walk without being issued, and `async_go` pulses.
- R9: A map write made during a walk governs every slot the walk has not yet reached.
- R10: A `frame_start` that arrives while a slot is issued is held pending. When `done` is sampled, the walk restarts at slot 0 with no `async_go` pulse. After the walk ends, the active index stays on the slot where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Register command strobe |
| cmd_code | input | 8 | Command code; bit 7 set means write |
| cmd_wdata | input | 32 | Write data |
| cmd_rdata | output | 32 | Read data for the current read code |
| frame_start | input | 1 | Start-of-frame pulse |
| issue | output | 1 | A slot is handed to the transaction engine |
| issue_slot | output | 5 | Index of the issued slot |
| done | input | 1 | Transaction engine finished the issued slot |
| async_go | output | 1 | One-cycle pulse that passes control to the asynchronous phase |

## Verification
The walk is exercised with four kinds of map patterns:
- Empty maps, which force all 32 issues and the top-slot stop.
- Fully excluded maps, which give the longest issue-free scan.
- Directed maps that place an end-of-list bit on an issued slot or on an excluded slot, which separate R6 from R8.
- Randomly drawn sparse end-of-list maps over random exclusion maps, which test the ordering and stop logic against a bench model.

The timing of the first event measures the one-cycle cost of each excluded slot. A mid-walk rewrite of the exclusion map shows whether the map is sampled late, slot by slot, or latched at frame start. A frame start during an open handshake shows whether the restart waits for `done` or drops the slot in flight.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam logic [6:0] REG_SKIP = 7'h18;
  localparam logic [6:0] REG_LAST = 7'h19;
  localparam logic [6:0] REG_CUR  = 7'h1A;

  typedef enum logic [1:0] {WK_IDLE, WK_SCAN, WK_WAIT} walk_st_e;
endpackage

// File: rtl/pss_regs.sv
module pss_regs #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic [DW-1:0]    cmd_wdata,
  input  logic [IW-1:0]    active_idx,
  output logic [SLOTS-1:0] skip_map,
  output logic [SLOTS-1:0] last_map,
  output logic [DW-1:0]    cmd_rdata
);
  import pss_pkg::*;

  logic [6:0] reg_sel;
  logic       wr_en, rd_en, wr_skip, wr_last;

  assign reg_sel = cmd_code[6:0];
  assign wr_en   = cmd_valid &&  cmd_code[7];
  assign rd_en   = cmd_valid && !cmd_code[7];
  assign wr_skip = wr_en && (reg_sel == REG_SKIP);
  assign wr_last = wr_en && (reg_sel == REG_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_map <= '0;
      last_map <= '0;
    end else begin
      if (wr_skip) skip_map <= cmd_wdata[SLOTS-1:0];
      if (wr_last) last_map <= cmd_wdata[SLOTS-1:0];
    end
  end

  always_comb begin
    cmd_rdata = '0;
    if (rd_en) begin
      case (reg_sel)
        REG_SKIP: cmd_rdata = DW'(skip_map);
        REG_LAST: cmd_rdata = DW'(last_map);
        REG_CUR:  cmd_rdata = DW'(active_idx);
        default:  cmd_rdata = '0;
      endcase
    end
  end

  a_r1_skip_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_skip |=> skip_map == $past(cmd_wdata[SLOTS-1:0]));
  a_r1_last_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |=> last_map == $past(cmd_wdata[SLOTS-1:0]));
  a_r2_other_writes_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_skip && !wr_last) |=> $stable(skip_map) && $stable(last_map));
endmodule

// File: rtl/pss_walk.sv
module pss_walk #(
  parameter int unsigned SLOTS = 32,
  localparam int unsigned IW   = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] skip_map,
  input  logic [SLOTS-1:0] last_map,
  input  logic             frame_start,
  input  logic             done,
  output logic             issue,
  output logic [IW-1:0]    issue_slot,
  output logic [IW-1:0]    active_idx,
  output logic             async_go
);
  import pss_pkg::*;

  function automatic logic slot_final(input logic last_bit, input logic [IW-1:0] i);
    return last_bit || (i == IW'(SLOTS - 1));
  endfunction

  function automatic logic [IW-1:0] slot_next(input logic [IW-1:0] i);
    return IW'(i + 1'b1);
  endfunction

  walk_st_e      st, st_n;
  logic [IW-1:0] idx, idx_n;
  logic          pend, pend_n, go;

  logic cur_skip, cur_final, in_flight;
  logic evt_restart, evt_slot_done, evt_skip, evt_end, evt_launch;

  assign cur_skip      = skip_map[idx];
  assign cur_final     = slot_final(last_map[idx], idx);
  assign in_flight     = (st == WK_WAIT);
  assign evt_restart   = (frame_start && !in_flight) ||
                         (in_flight && done && (pend || frame_start));
  assign evt_slot_done = in_flight && done && !evt_restart;
  assign evt_skip      = (st == WK_SCAN) && !frame_start && cur_skip;
  assign evt_launch    = (st == WK_SCAN) && !frame_start && !cur_skip;
  assign evt_end       = (evt_slot_done || evt_skip) && cur_final;

  always_comb begin
    st_n   = st;
    idx_n  = idx;
    pend_n = pend;
    if (evt_restart) begin
      st_n   = WK_SCAN;
      idx_n  = '0;
      pend_n = 1'b0;
    end else begin
      if (in_flight && frame_start) pend_n = 1'b1;
      if (evt_end) begin
        st_n = WK_IDLE;
      end else if (evt_slot_done || evt_skip) begin
        st_n  = WK_SCAN;
        idx_n = slot_next(idx);
      end else if (evt_launch) begin
        st_n = WK_WAIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= WK_IDLE;
      idx  <= '0;
      pend <= 1'b0;
      go   <= 1'b0;
    end else begin
      st   <= st_n;
      idx  <= idx_n;
      pend <= pend_n;
      go   <= evt_end;
    end
  end

  assign issue      = in_flight;
  assign issue_slot = idx;
  assign active_idx = idx;
  assign async_go   = go;

  a_r5_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !done) |=> issue && $stable(issue_slot));
  a_r8_no_excluded_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue) |-> !$past(skip_map[idx]));
  a_r6_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    async_go |=> !async_go);
  a_r6_go_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    async_go |-> !issue);
  a_r7_top_slot_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == WK_SCAN) && (idx == IW'(SLOTS - 1)) && cur_skip && !frame_start) |=> async_go);
  a_r10_pending_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && done && (frame_start || pend)) |=> !async_go && (active_idx == '0));
endmodule

// File: rtl/periodic_slot_sched.sv
module periodic_slot_sched #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_code,
  input  logic [DW-1:0] cmd_wdata,
  output logic [DW-1:0] cmd_rdata,
  input  logic          frame_start,
  output logic          issue,
  output logic [IW-1:0] issue_slot,
  input  logic          done,
  output logic          async_go
);
  logic [SLOTS-1:0] skip_map, last_map;
  logic [IW-1:0]    active_idx;

  pss_regs #(.SLOTS(SLOTS), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_wdata(cmd_wdata), .active_idx(active_idx), .skip_map(skip_map),
    .last_map(last_map), .cmd_rdata(cmd_rdata)
  );

  pss_walk #(.SLOTS(SLOTS)) u_walk (
    .clk(clk), .rst_n(rst_n), .skip_map(skip_map), .last_map(last_map),
    .frame_start(frame_start), .done(done), .issue(issue),
    .issue_slot(issue_slot), .active_idx(active_idx), .async_go(async_go)
  );
endmodule

// File: tb/periodic_slot_sched_bench.sv
module periodic_slot_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        frame_start = 1'b0;
  logic        issue;
  logic [4:0]  issue_slot;
  logic        done = 1'b0;
  logic        async_go;

  int n_chk = 0;
  int n_bad = 0;

  periodic_slot_sched u_periodic_slot_sched (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .frame_start(frame_start),
    .issue(issue), .issue_slot(issue_slot), .done(done), .async_go(async_go)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] code, output logic [31:0] v);
    cmd_code = code; cmd_valid = 1'b1;
    #1 v = cmd_rdata;
    cmd_valid = 1'b0; cmd_code = '0;
  endtask

  task automatic wr(input logic [7:0] code, input logic [31:0] data);
    cmd_code = code; cmd_wdata = data; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = '0;
  endtask

  // Model of one walk: issued slots, stop slot, slot of the first event
  function automatic void exp_walk(input logic [31:0] sk, input logic [31:0] la,
                                   output int sl[32], output int cnt,
                                   output int endslot, output int first);
    cnt = 0; endslot = 31; first = -1;
    for (int i = 0; i < 32; i++) sl[i] = -1;
    for (int i = 0; i < 32; i++) begin
      if (!sk[i]) begin sl[cnt] = i; cnt++; end
      if (first < 0 && (!sk[i] || la[i])) first = i;
      if (la[i]) begin endslot = i; break; end
    end
    if (first < 0) first = 31;
  endfunction

  task automatic start_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // Called at the first negedge after the restart edge
  task automatic run_walk(input logic [31:0] sk, input logic [31:0] la, input int hook_slot,
                          input logic [31:0] hook_skip, input string tag);
    int sl[32];
    int cnt, endslot, first, n, got, slot, wt;
    bit fin, seen, adv;
    logic [31:0] v;
    exp_walk((hook_slot >= 0) ? hook_skip : sk, la, sl, cnt, endslot, first);
    n = 1; got = 0; fin = 0; seen = 0;
    while (!fin && n < 400) begin
      adv = 1;
      if (async_go) begin
        if (!seen) chk(n == first + 2, {tag, " R4 first-event timing"}, n, first + 2);
        chk(got == cnt, {tag, " R6/R7 issue count at hand-off"}, got, cnt);
        rd(8'h1A, v);
        chk(v == 32'(endslot), {tag, " R10 index after stop"}, v, endslot);
        @(negedge clk);
        chk(!async_go && !issue, {tag, " R6 single pulse"}, async_go, 0);
        fin = 1; adv = 0;
      end else if (issue) begin
        if (!seen) chk(n == first + 2, {tag, " R4 first-issue timing"}, n, first + 2);
        seen = 1;
        slot = int'(issue_slot);
        chk(got < cnt && slot == sl[got], {tag, " R4/R5 issue order"}, slot, (got < 32) ? sl[got] : -1);
        rd(8'h1A, v);
        chk(v == 32'(slot), {tag, " R5 readout tracks issue"}, v, slot);
        if (hook_slot == slot) wr(8'h98, hook_skip);
        wt = $urandom_range(0, 3);
        repeat (wt) @(negedge clk);
        chk(issue && int'(issue_slot) == slot, {tag, " R5 held until done"}, issue_slot, slot);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        got++; n++; adv = 0;
      end
      if (adv) begin @(negedge clk); n++; end
    end
    if (!fin) chk(0, {tag, " R6 walk never handed off"}, n, 0);
  endtask

  task automatic full_walk(input logic [31:0] sk, input logic [31:0] la, input string tag);
    wr(8'h98, sk);
    wr(8'h99, la);
    start_frame();
    run_walk(sk, la, -1, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, sk, la;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    rd(8'h18, v); chk(v == 0, "R3 exclusion map reset", v, 0);
    rd(8'h19, v); chk(v == 0, "R3 end map reset", v, 0);
    rd(8'h1A, v); chk(v == 0, "R3 index reset", v, 0);
    chk(!issue && !async_go, "R3 outputs idle", {issue, async_go}, 0);

    // R2 read-only index, unknown codes
    wr(8'h9A, 32'hFFFF_FFFF);
    wr(8'h9B, 32'hFFFF_FFFF);
    rd(8'h1A, v); chk(v == 0, "R2 write to index ignored", v, 0);
    rd(8'h18, v); chk(v == 0, "R2 unknown write leaves exclusion map", v, 0);
    rd(8'h19, v); chk(v == 0, "R2 unknown write leaves end map", v, 0);
    rd(8'h05, v); chk(v == 0, "R2 unknown read is zero", v, 0);
    #1 chk(cmd_rdata == 0, "R2 idle port reads zero", cmd_rdata, 0);

    // R1 readback
    wr(8'h98, 32'hA5C3_0F17);
    rd(8'h18, v); chk(v == 32'hA5C3_0F17, "R1 exclusion map readback", v, 32'hA5C3_0F17);
    wr(8'h99, 32'h1234_8001);
    rd(8'h19, v); chk(v == 32'h1234_8001, "R1 end map readback", v, 32'h1234_8001);
    rd(8'h18, v); chk(v == 32'hA5C3_0F17, "R1 maps independent", v, 32'hA5C3_0F17);

    // Directed walks
    full_walk(32'h0, 32'h0, "R7 empty maps");
    full_walk(32'hFFFF_FFFF, 32'h0, "R7 all excluded");
    full_walk(32'h0000_000F, 32'h0000_0008, "R8 excluded last");
    full_walk(32'h0000_0007, 32'h0000_0020, "R4 skip cost");
    rd(8'h1A, v); chk(v == 5, "R10 index holds after stop", v, 5);

    // R9 mid-walk exclusion write
    wr(8'h98, 32'h0);
    wr(8'h99, 32'h0000_0040);
    start_frame();
    run_walk(32'h0, 32'h0000_0040, 1, 32'h0000_0008, "R9 late write");

    // R10 frame start during an open handshake
    wr(8'h98, 32'h0);
    wr(8'h99, 32'h0000_0010);
    start_frame();
    @(negedge clk);
    chk(issue && issue_slot == 0, "R10 slot 0 issued", issue_slot, 0);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(issue && issue_slot == 0, "R10 pending keeps slot", issue_slot, 0);
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(!async_go, "R10 no hand-off on restart", async_go, 0);
    run_walk(32'h0, 32'h0000_0010, -1, '0, "R10 restart");

    // Random walks
    for (int t = 0; t < 25; t++) begin
      sk = $urandom;
      la = $urandom & $urandom & $urandom & $urandom;
      if (t % 5 == 0) la = '0;
      full_walk(sk, la, "R4 random walk");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule